// File: doc/BRIEF.md
# Receive Sample Formatter and Packer

The block sits between a digital downconverter and a 16-bit host transport. Each cycle it can take one complex sample, made of a signed 16-bit in-phase part and a signed 16-bit quadrature part. One 32-bit format control word sets how samples are turned into transport words. Each part is shifted right arithmetically by the programmed amount and then cut to the programmed width. The block sends both parts or the in-phase part alone. Narrow results are packed so that two of them fill one 16-bit word.

The format word also carries a flag that tells the upstream half-band filter stage to step aside. The block does not use this flag itself. It exports it on a dedicated output. A format write with reserved bits set, or with a width/shift pairing the datapath does not support, is refused. A one-cycle flag reports the refusal and the active format is left unchanged. Both sides use valid/ready handshakes. When the transport holds off, the input is stalled and no sample is lost.

Top module: `rxfmt_top`

## Requirements
- R1: After reset the active format equals the word 0x00000300: 16-bit samples, no shift, both parts delivered, filter bypass off. out_valid and cfg_reject are low, in_ready is high and hb_bypass is low.
- R2: Field positions in the format word: bits [3:0] give the right-shift amount, bits [8:4] give the sample width, bit 9 set means both parts and clear means in-phase only, bit 10 requests the filter bypass, and bits [31:11] are reserved.
- R3: A write is legal only when the reserved bits are zero and the (width, shift) pair is (16, 0) or (8, 8). With EXT_MODES=1, bits 9 and 10 may take either value. With EXT_MODES=0 they must be 1 and 0. An illegal write raises cfg_reject for exactly the cycle after the write, and the previous format stays active.
- R4: hb_bypass follows bit 10 of the active format. It changes only in the cycle after an accepted write.
- R5: In 16-bit mode with both parts, each sample produces two words: the in-phase value, then the quadrature value. When the transport is ready, the second word follows the first in the very next cycle.
- R6: In 16-bit in-phase-only mode, each sample produces one word equal to its in-phase value. The quadrature input has no effect on the output.
- R7: In 8-bit mode with both parts, each sample produces one word. The low byte is the in-phase value shifted right arithmetically by 8 (its upper byte). The high byte is the quadrature value treated the same way.
- R8: In 8-bit in-phase-only mode, two consecutive samples produce one word. The older in-phase byte goes in the low half and the newer one in the high half. Both bytes are formed as in R7.
- R9: While out_valid is high and out_ready is low, out_valid stays high and out_data holds its value. in_ready stays low while a second word of a sample is still owed. Every accepted sample appears at the output, in order.
- R10: An accepted write applies to samples taken after its cycle. In 8-bit in-phase-only mode, an unpaired byte that is waiting for its partner is discarded when the write is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Format word write strobe |
| cfg_wr_data | input | 32 | Format word to write |
| cfg_reject | output | 1 | One-cycle flag for a refused write |
| hb_bypass | output | 1 | Bypass request to the half-band filter stage |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Block can take a sample this cycle |
| in_i | input | 16 | In-phase sample, signed |
| in_q | input | 16 | Quadrature sample, signed |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Transport accepts the output word |
| out_data | output | 16 | Formatted output word |

## Verification
Several rules are checked by assertions on every cycle. A stalled word must stay put. No new sample may be taken while a quadrature word is owed, and that word must follow at once when the transport is ready. Writes with reserved bits must be refused, and a refusal must leave the format untouched. The bypass output may change only after a write. What the assertions cannot show is whether the words carry the right bytes in the right order in each of the four modes. They also cannot show that the unpaired byte is dropped on a format change, or that nothing is lost under random backpressure. The bench scenarios cover these by comparing against a queue of expected words built from the requirements.

// File: rtl/rxfmt_pkg.sv
package rxfmt_pkg;

    // Active format held by the configuration stage.
    typedef struct packed {
        logic [3:0] shift;   // arithmetic right shift amount
        logic       narrow;  // 1: half-width samples, 0: full-width samples
        logic       want_q;  // 1: deliver both parts, 0: in-phase only
        logic       bypass;  // filter bypass request
    } fmt_cfg_t;

    localparam int          CFG_W     = 32;
    localparam logic [31:0] FMT_RESET = 32'h0000_0300;

    // Field positions inside the control word.
    localparam int SHIFT_LSB = 0;
    localparam int SHIFT_W   = 4;
    localparam int WIDTH_LSB = 4;
    localparam int WIDTH_W   = 5;
    localparam int QSEL_BIT  = 9;
    localparam int BYP_BIT   = 10;
    localparam int RSVD_LSB  = 11;

endpackage

// File: rtl/rxfmt_cfg.sv
module rxfmt_cfg
    import rxfmt_pkg::*;
#(
    parameter int SAMPLE_W  = 16,
    parameter bit EXT_MODES = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CFG_W-1:0]  wr_data,
    output fmt_cfg_t          cfg_o,
    output logic              take_o,
    output logic              reject_o,
    output logic              bypass_o
);

    localparam int NARROW_W   = SAMPLE_W / 2;
    localparam int NARROW_SHR = SAMPLE_W - NARROW_W;

    typedef struct packed {
        fmt_cfg_t cfg;
        logic     reject;
    } cfg_state_t;

    cfg_state_t state_d, state_q;

    logic [SHIFT_W-1:0] f_shift;
    logic [WIDTH_W-1:0] f_width;
    logic               f_q;
    logic               f_b;
    logic               rsvd_clear;
    logic               pair_ok;
    logic               mode_ok;
    logic               legal;
    fmt_cfg_t           reset_cfg;
    fmt_cfg_t           new_cfg;

    always_comb begin
        f_shift    = wr_data[SHIFT_LSB +: SHIFT_W];
        f_width    = wr_data[WIDTH_LSB +: WIDTH_W];
        f_q        = wr_data[QSEL_BIT];
        f_b        = wr_data[BYP_BIT];
        rsvd_clear = (wr_data[CFG_W-1:RSVD_LSB] == '0);
        pair_ok    = ((f_width == WIDTH_W'(SAMPLE_W)) && (f_shift == '0)) ||
                     ((f_width == WIDTH_W'(NARROW_W)) && (f_shift == SHIFT_W'(NARROW_SHR)));
    end

    generate
        if (EXT_MODES) begin : g_ext
            assign mode_ok = 1'b1;
        end else begin : g_strict
            assign mode_ok = f_q && !f_b;
        end
    endgenerate

    always_comb begin
        legal = rsvd_clear && pair_ok && mode_ok;

        new_cfg.shift  = f_shift;
        new_cfg.narrow = (f_width == WIDTH_W'(NARROW_W));
        new_cfg.want_q = f_q;
        new_cfg.bypass = f_b;

        reset_cfg.shift  = FMT_RESET[SHIFT_LSB +: SHIFT_W];
        reset_cfg.narrow = (FMT_RESET[WIDTH_LSB +: WIDTH_W] == WIDTH_W'(NARROW_W));
        reset_cfg.want_q = FMT_RESET[QSEL_BIT];
        reset_cfg.bypass = FMT_RESET[BYP_BIT];

        state_d        = state_q;
        state_d.reject = wr_en && !legal;
        if (wr_en && legal) begin
            state_d.cfg = new_cfg;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q.cfg    <= reset_cfg;
            state_q.reject <= 1'b0;
        end else begin
            state_q <= state_d;
        end
    end

    assign cfg_o    = state_q.cfg;
    assign take_o   = wr_en && legal;
    assign reject_o = state_q.reject;
    assign bypass_o = state_q.cfg.bypass;

    // R3: a write touching reserved bits is always refused
    assert_rsvd_refused_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_data[CFG_W-1:RSVD_LSB] != '0)) |=> reject_o);

    // R3: a refusal leaves the active format unchanged
    assert_refusal_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
        reject_o |-> $stable(cfg_o));

    // R4: the bypass output moves only after a write
    assert_bypass_after_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(bypass_o) |-> $past(wr_en));

endmodule

// File: rtl/rxfmt_shaper.sv
module rxfmt_shaper
    import rxfmt_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    parameter int LANES    = 2
) (
    input  logic [LANES*SAMPLE_W-1:0] lanes_i,
    input  logic [SHIFT_W-1:0]        shift_i,
    output logic [LANES*SAMPLE_W-1:0] lanes_o
);

    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_lane
            logic signed [SAMPLE_W-1:0] raw;
            logic signed [SAMPLE_W-1:0] shifted;
            always_comb begin
                raw     = lanes_i[g*SAMPLE_W +: SAMPLE_W];
                shifted = raw >>> shift_i;
            end
            assign lanes_o[g*SAMPLE_W +: SAMPLE_W] = shifted;
        end
    endgenerate

endmodule

// File: rtl/rxfmt_packer.sv
module rxfmt_packer
    import rxfmt_pkg::*;
#(
    parameter int SAMPLE_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  fmt_cfg_t            cfg_i,
    input  logic                flush_i,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [SAMPLE_W-1:0] i_sh,
    input  logic [SAMPLE_W-1:0] q_sh,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [SAMPLE_W-1:0] out_data
);

    localparam int NARROW_W = SAMPLE_W / 2;

    typedef struct packed {
        logic                out_valid;
        logic [SAMPLE_W-1:0] out_data;
        logic                pend_valid;
        logic [SAMPLE_W-1:0] pend_data;
        logic                half_valid;
        logic [NARROW_W-1:0] half_byte;
    } pack_state_t;

    pack_state_t state_d, state_q;

    logic                slot_free;
    logic                in_fire;
    logic [NARROW_W-1:0] i_b;
    logic [NARROW_W-1:0] q_b;

    always_comb begin
        slot_free = !state_q.out_valid || out_ready;
        in_ready  = slot_free && !state_q.pend_valid;
        in_fire   = in_valid && in_ready;
        i_b       = i_sh[NARROW_W-1:0];
        q_b       = q_sh[NARROW_W-1:0];

        state_d = state_q;
        if (state_q.out_valid && out_ready) begin
            state_d.out_valid = 1'b0;
        end

        if (state_q.pend_valid && slot_free) begin
            state_d.out_valid  = 1'b1;
            state_d.out_data   = state_q.pend_data;
            state_d.pend_valid = 1'b0;
        end else if (in_fire) begin
            unique case ({cfg_i.narrow, cfg_i.want_q})
                2'b01: begin
                    state_d.out_valid  = 1'b1;
                    state_d.out_data   = i_sh;
                    state_d.pend_valid = 1'b1;
                    state_d.pend_data  = q_sh;
                end
                2'b00: begin
                    state_d.out_valid = 1'b1;
                    state_d.out_data  = i_sh;
                end
                2'b11: begin
                    state_d.out_valid = 1'b1;
                    state_d.out_data  = {q_b, i_b};
                end
                default: begin
                    if (state_q.half_valid) begin
                        state_d.out_valid  = 1'b1;
                        state_d.out_data   = {i_b, state_q.half_byte};
                        state_d.half_valid = 1'b0;
                    end else begin
                        state_d.half_byte  = i_b;
                        state_d.half_valid = 1'b1;
                    end
                end
            endcase
        end

        if (flush_i) begin
            state_d.half_valid = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign out_valid = state_q.out_valid;
    assign out_data  = state_q.out_data;

    // R9: a stalled word stays valid and unchanged
    assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R9: no new sample is taken while a second word is owed
    assert_owed_blocks_input_R9: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.pend_valid |-> !in_ready);

    // R5: the owed quadrature word follows at once when the transport is ready
    assert_q_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.pend_valid && out_valid && out_ready) |=> out_valid);

endmodule

// File: rtl/rxfmt_top.sv
module rxfmt_top
    import rxfmt_pkg::*;
#(
    parameter int SAMPLE_W  = 16,
    parameter bit EXT_MODES = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_wr_en,
    input  logic [31:0]         cfg_wr_data,
    output logic                cfg_reject,
    output logic                hb_bypass,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [SAMPLE_W-1:0] in_i,
    input  logic [SAMPLE_W-1:0] in_q,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [SAMPLE_W-1:0] out_data
);

    localparam int LANES = 2;

    fmt_cfg_t                  cfg;
    logic                      cfg_take;
    logic [LANES*SAMPLE_W-1:0] raw_lanes;
    logic [LANES*SAMPLE_W-1:0] sh_lanes;

    rxfmt_cfg #(
        .SAMPLE_W (SAMPLE_W),
        .EXT_MODES(EXT_MODES)
    ) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr_en),
        .wr_data (cfg_wr_data),
        .cfg_o   (cfg),
        .take_o  (cfg_take),
        .reject_o(cfg_reject),
        .bypass_o(hb_bypass)
    );

    assign raw_lanes = {in_q, in_i};

    rxfmt_shaper #(
        .SAMPLE_W(SAMPLE_W),
        .LANES   (LANES)
    ) u_shaper (
        .lanes_i(raw_lanes),
        .shift_i(cfg.shift),
        .lanes_o(sh_lanes)
    );

    rxfmt_packer #(
        .SAMPLE_W(SAMPLE_W)
    ) u_packer (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_i    (cfg),
        .flush_i  (cfg_take),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .i_sh     (sh_lanes[0 +: SAMPLE_W]),
        .q_sh     (sh_lanes[SAMPLE_W +: SAMPLE_W]),
        .out_valid(out_valid),
        .out_ready(out_ready),
        .out_data (out_data)
    );

endmodule

// File: tb/rxfmt_top_tb.sv
module rxfmt_top_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [31:0] cfg_wr_data = '0;
    logic        cfg_reject;
    logic        hb_bypass;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] in_i = '0;
    logic [15:0] in_q = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [15:0] out_data;

    int compared   = 0;
    int mismatched = 0;
    int cycles     = 0;
    bit stall_en   = 1'b0;
    bit done       = 1'b0;

    // bench model of the active format
    bit          m_narrow = 1'b0;
    bit          m_q      = 1'b1;
    bit          half_have = 1'b0;
    logic [7:0]  half_b;

    logic [15:0] exp_q[$];
    string       tag_q[$];

    bit          hold_chk = 1'b0;
    logic [15:0] prev_data;

    always #10 clk = ~clk;

    rxfmt_top u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr_en  (cfg_wr_en),
        .cfg_wr_data(cfg_wr_data),
        .cfg_reject (cfg_reject),
        .hb_bypass  (hb_bypass),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_i       (in_i),
        .in_q       (in_q),
        .out_valid  (out_valid),
        .out_ready  (out_ready),
        .out_data   (out_data)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // backpressure driver
    always @(posedge clk) begin
        #1;
        out_ready = stall_en ? 1'($urandom % 2) : 1'b1;
    end

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (hold_chk) begin
                check(out_valid && (out_data == prev_data), "R9 stall hold", {15'd0, out_valid, out_data}, {16'd1, prev_data});
            end
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R9 unexpected word", {16'd0, out_data}, 32'd0);
                end else begin
                    logic [15:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(out_data == e, t, {16'd0, out_data}, {16'd0, e});
                end
            end
            hold_chk  = out_valid && !out_ready;
            prev_data = out_data;
        end
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            mismatched++;
            compared++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    // Called at posedge+1; returns at posedge+1.
    task automatic send(input logic [15:0] i, input logic [15:0] q, input string tag);
        in_i = i;
        in_q = q;
        in_valid = 1'b1;
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        if (!m_narrow && m_q) begin
            exp_q.push_back(i); tag_q.push_back({tag, " I word"});
            exp_q.push_back(q); tag_q.push_back({tag, " Q word"});
        end else if (!m_narrow) begin
            exp_q.push_back(i); tag_q.push_back(tag);
        end else if (m_q) begin
            exp_q.push_back({q[15:8], i[15:8]}); tag_q.push_back(tag);
        end else if (half_have) begin
            exp_q.push_back({i[15:8], half_b}); tag_q.push_back(tag);
            half_have = 1'b0;
        end else begin
            half_b = i[15:8];
            half_have = 1'b1;
        end
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    task automatic cfg_write(input logic [31:0] w, input bit exp_rej, input bit exp_byp, input string tag);
        cfg_wr_data = w;
        cfg_wr_en = 1'b1;
        @(posedge clk);
        #1;
        cfg_wr_en = 1'b0;
        @(negedge clk);
        check(cfg_reject == exp_rej, {tag, " reject flag"}, {31'd0, cfg_reject}, {31'd0, exp_rej});
        check(hb_bypass == exp_byp, {tag, " bypass"}, {31'd0, hb_bypass}, {31'd0, exp_byp});
        if (!exp_rej) begin
            m_narrow  = (w[8:4] == 5'd8);
            m_q       = w[9];
            half_have = 1'b0;
        end
        @(posedge clk);
        #1;
        check(cfg_reject == 1'b0, {tag, " reject one cycle"}, {31'd0, cfg_reject}, 32'd0);
    endtask

    task automatic drain(input string tag);
        int n;
        n = 0;
        while (exp_q.size() != 0 && n < 2000) begin
            @(negedge clk);
            n++;
        end
        check(exp_q.size() == 0, {tag, " all words delivered"}, exp_q.size(), 32'd0);
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R1 out_valid after reset", {31'd0, out_valid}, 32'd0);
        check(in_ready == 1'b1, "R1 in_ready after reset", {31'd0, in_ready}, 32'd1);
        check(hb_bypass == 1'b0, "R1 bypass after reset", {31'd0, hb_bypass}, 32'd0);
        check(cfg_reject == 1'b0, "R1 reject after reset", {31'd0, cfg_reject}, 32'd0);
        @(posedge clk);
        #1;

        // R1 / R5: default format, 16-bit I then Q
        send(16'h1234, 16'hABCD, "R1 R5 default");
        send(16'h8001, 16'h7FFF, "R5 extremes");
        send(16'hFFFF, 16'h0000, "R5 sign");
        drain("R5");

        // R2 / R7: width 8 shift 8, both parts
        cfg_write(32'h0000_0288, 1'b0, 1'b0, "R2 narrow IQ");
        send(16'h12F0, 16'hAB0F, "R7 bytes");
        send(16'h8000, 16'h7FFF, "R7 extremes");
        send(16'h00FF, 16'hFF00, "R7 low bits dropped");
        drain("R7");

        // R8 / R10: width 8 shift 8, in-phase only
        cfg_write(32'h0000_0088, 1'b0, 1'b0, "R2 narrow I");
        send(16'h1100, 16'hDEAD, "R8 pair A");
        send(16'h2200, 16'hBEEF, "R8 pair A");
        send(16'hF3FF, 16'h0000, "R8 pair B");
        send(16'h8400, 16'h1111, "R8 pair B");
        send(16'h5500, 16'h0000, "R10 unpaired");
        drain("R8");
        cfg_write(32'h0000_0300, 1'b0, 1'b0, "R10 rewrite default");
        send(16'h0A0B, 16'h0C0D, "R10 after flush");
        drain("R10");

        // R6: 16-bit in-phase only
        cfg_write(32'h0000_0100, 1'b0, 1'b0, "R2 wide I");
        send(16'h4321, 16'h9999, "R6 q ignored");
        send(16'h4321, 16'h0001, "R6 q ignored");
        send(16'hC000, 16'hFFFF, "R6 negative");
        drain("R6");

        // R4: bypass bit
        cfg_write(32'h0000_0700, 1'b0, 1'b1, "R4 bypass set");
        send(16'h0001, 16'h0002, "R4 data path kept");
        drain("R4");
        cfg_write(32'h0000_0300, 1'b0, 1'b0, "R4 bypass clear");

        // R3: refused writes
        cfg_write(32'h0000_0B00, 1'b1, 1'b0, "R3 reserved bit");
        cfg_write(32'h8000_0300, 1'b1, 1'b0, "R3 top reserved bit");
        cfg_write(32'h0000_04C0, 1'b1, 1'b0, "R3 width 12");
        cfg_write(32'h0000_0303, 1'b1, 1'b0, "R3 wide with shift");
        cfg_write(32'h0000_0280, 1'b1, 1'b0, "R3 narrow no shift");
        send(16'h7654, 16'h3210, "R3 format kept");
        drain("R3");

        // R9: random backpressure in each mode
        stall_en = 1'b1;
        for (int k = 0; k < 24; k++) send(16'(k * 16'h0911), 16'(16'hF000 - k * 16'h0123), "R9 wide IQ stall");
        drain("R9 wide IQ");
        cfg_write(32'h0000_0288, 1'b0, 1'b0, "R9 narrow IQ cfg");
        for (int k = 0; k < 24; k++) send(16'(k * 16'h1357), 16'(16'h8000 + k * 16'h0777), "R9 narrow IQ stall");
        drain("R9 narrow IQ");
        cfg_write(32'h0000_0088, 1'b0, 1'b0, "R9 narrow I cfg");
        for (int k = 0; k < 24; k++) send(16'(k * 16'h2468), 16'h0, "R9 narrow I stall");
        drain("R9 narrow I");
        stall_en = 1'b0;

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule